// File: doc/BRIEF.md
# I2C Slave Status-Flag Controller

This block is the target side of a two-wire serial bus. It watches the clock and data lines for START, repeated START and STOP conditions. After each START it compares the incoming 7-bit address with its own. On a match it acknowledges and then either collects bytes written by the master or shifts out bytes for the master to read.

The bus side is open-drain. The block takes the filtered line levels as inputs and pulls data low through a single output-enable. The host side is a strobe-based register port. It has:

- a write strobe that fills a transmit holding register;
- a read strobe that consumes the receive holding register;
- a status read strobe.

The status bits are continuously visible:

- an access-active flag;
- a direction flag;
- an end-of-access flag;
- a receive-ready flag;
- a transmit-ready flag.

Software polls these to move data one byte at a time.

Top module: `i2c_slave_flags`

## Requirements
- R1: After reset the access, direction, end-of-access and receive-ready flags read 0, transmit-ready reads 1 and the data line is not pulled low.
- R2: When the address byte after a START or repeated START carries an address other than `own_addr`, the block leaves the ACK slot released (NACK) and the access flag stays or becomes 0. Later bytes of that transfer are neither acknowledged nor stored, so receive-ready stays 0.
- R3: The address byte is sent MSB first, with the 7 address bits followed by the R/W bit. On a match the block pulls data low in the ACK slot, sets the access flag and loads the direction flag from R/W (0 = master writes, 1 = master reads).
- R4: A repeated START followed by the matching address keeps the access flag at 1, reloads the direction flag, and does not set end-of-access.
- R5: In a master write, each byte (MSB first) is acknowledged and copied to `rx_rdata` when its eighth bit is sampled, at which point receive-ready is set. A `rx_rd` strobe clears receive-ready.
- R6: A STOP, or a repeated START followed by a non-matching address, clears the access flag. When the access flag was 1, the same event sets end-of-access. A `stat_rd` strobe clears end-of-access. A STOP while the access flag is 0 leaves end-of-access unchanged.
- R7: In a master read, the transmit holding register is moved into the shift register on the SCL falling edge that ends the preceding ACK slot, and transmit-ready drops to 0. The byte goes out MSB first. Transmit-ready returns to 1 when the master's ACK or NACK bit is sampled.
- R8: If no byte has been written to the transmit holding register since its last move, the byte shifted out is 0xFF.
- R9: After a master NACK the block releases the data line and drives no further bits until the next START or repeated START.
- R10: A high pulse on SCL shorter than `FILT_LEN` clock cycles is ignored and does not advance the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Programmed slave address |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_rdata | output | 8 | Receive holding register |
| stat_rd | input | 1 | Status read strobe |
| st_acc | output | 1 | Slave access active |
| st_dir | output | 1 | Transfer direction (valid while st_acc is 1) |
| st_eoa | output | 1 | End of slave access |
| st_rxrdy | output | 1 | Receive holding register full |
| st_txrdy | output | 1 | Transmit byte consumed and acknowledged |

## Verification
A bit counter that is off by one inside the engine appears at the port within one byte time. It shows as a missing or misplaced ACK pull on `sda_oe`, a shifted `rx_rdata` value, or a ready flag that rises a bit early or late. A flag register stuck in the wrong state is visible on the status outputs within a few clock cycles of the bus event that should have moved it. The bench therefore checks the flags right after each SCL phase and checks the ACK slot and data values on every byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_PARK
   } eng_state_t;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], din};
   end

   if (FILT_LEN < 0) begin : g_bad_len
      $error("i2cs_line_filter: FILT_LEN must not be negative");
   end

   if (FILT_LEN == 0) begin : g_bypass
      assign dout = sync_q[1];
   end else begin : g_filter
      localparam int CW = $clog2(FILT_LEN + 1);
      logic [CW-1:0] cnt_q;
      logic          out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b1;
         end else if (sync_q[1] != out_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
               out_q <= sync_q[1];
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
      assign dout = out_q;
   end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              sda_oe,
   output logic              rw,
   output logic              ev_match,
   output logic              ev_miss,
   output logic              ev_stop,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_byte,
   output logic              tx_load,
   output logic              tx_done
);
   localparam int BCNT_W = $clog2(DATA_W + 1);
   localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);
   localparam logic [BCNT_W-1:0] FULL_CNT = BCNT_W'(DATA_W);

   eng_state_t        state_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic [DATA_W-1:0] sh_q;
   logic              scl_q, sda_q, mack_q;

   wire scl_rise = scl & ~scl_q;
   wire scl_fall = ~scl & scl_q;
   wire cond_start = scl & scl_q & sda_q & ~sda;
   wire cond_stop  = scl & scl_q & ~sda_q & sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bcnt_q   <= '0;
         sh_q     <= '0;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         mack_q   <= 1'b1;
         sda_oe   <= 1'b0;
         rw       <= 1'b0;
         ev_match <= 1'b0;
         ev_miss  <= 1'b0;
         ev_stop  <= 1'b0;
         rx_push  <= 1'b0;
         tx_load  <= 1'b0;
         tx_done  <= 1'b0;
      end else begin
         scl_q    <= scl;
         sda_q    <= sda;
         ev_match <= 1'b0;
         ev_miss  <= 1'b0;
         ev_stop  <= 1'b0;
         rx_push  <= 1'b0;
         tx_load  <= 1'b0;
         tx_done  <= 1'b0;
         if (cond_stop) begin
            state_q <= ST_IDLE;
            sda_oe  <= 1'b0;
            ev_stop <= 1'b1;
         end else if (cond_start) begin
            state_q <= ST_ADDR;
            bcnt_q  <= '0;
            sda_oe  <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh_q   <= {sh_q[DATA_W-2:0], sda};
                     bcnt_q <= bcnt_q + 1'b1;
                  end else if (scl_fall && bcnt_q == FULL_CNT) begin
                     if (sh_q[DATA_W-1:1] == own_addr) begin
                        sda_oe   <= 1'b1;
                        rw       <= sh_q[0];
                        ev_match <= 1'b1;
                        state_q  <= ST_AACK;
                     end else begin
                        ev_miss <= 1'b1;
                        state_q <= ST_PARK;
                     end
                  end
               end
               ST_AACK, ST_WACK: begin
                  if (scl_fall) begin
                     bcnt_q <= '0;
                     if (state_q == ST_AACK && rw) begin
                        sh_q    <= tx_byte;
                        sda_oe  <= ~tx_byte[DATA_W-1];
                        tx_load <= 1'b1;
                        state_q <= ST_RDAT;
                     end else begin
                        sda_oe  <= 1'b0;
                        state_q <= ST_WDAT;
                     end
                  end
               end
               ST_WDAT: begin
                  if (scl_rise) begin
                     sh_q   <= {sh_q[DATA_W-2:0], sda};
                     bcnt_q <= bcnt_q + 1'b1;
                     if (bcnt_q == LAST_BIT) rx_push <= 1'b1;
                  end else if (scl_fall && bcnt_q == FULL_CNT) begin
                     sda_oe  <= 1'b1;
                     state_q <= ST_WACK;
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (bcnt_q == LAST_BIT) begin
                        sda_oe  <= 1'b0;
                        bcnt_q  <= '0;
                        state_q <= ST_RACK;
                     end else begin
                        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
                        sda_oe <= ~sh_q[DATA_W-2];
                        bcnt_q <= bcnt_q + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack_q  <= sda;
                     tx_done <= 1'b1;
                  end else if (scl_fall) begin
                     if (!mack_q) begin
                        sh_q    <= tx_byte;
                        sda_oe  <= ~tx_byte[DATA_W-1];
                        tx_load <= 1'b1;
                        state_q <= ST_RDAT;
                     end else begin
                        sda_oe  <= 1'b0;
                        state_q <= ST_PARK;
                     end
                  end
               end
               default: sda_oe <= 1'b0;
            endcase
         end
      end
   end

   assign rx_byte = sh_q;
endmodule

// File: rtl/i2c_slave_flags.sv
module i2c_slave_flags #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 7,
   parameter int FILT_LEN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_rdata,
   input  logic              stat_rd,
   output logic              st_acc,
   output logic              st_dir,
   output logic              st_eoa,
   output logic              st_rxrdy,
   output logic              st_txrdy
);
   if (ADDR_W + 1 != DATA_W) begin : g_bad_width
      $error("i2c_slave_flags: address plus R/W bit must fill one byte");
   end

   logic [1:0] raw_lines, flt_lines;
   assign raw_lines = {scl_i, sda_i};

   for (genvar gi = 0; gi < 2; gi++) begin : g_line
      i2cs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_lines[gi]),
         .dout (flt_lines[gi])
      );
   end

   logic              rw, ev_match, ev_miss, ev_stop, rx_push, tx_load, tx_done;
   logic [DATA_W-1:0] rx_byte, tx_src, thr_q, rhr_q;
   logic              thr_full_q, acc_q, dir_q, eoa_q, rxrdy_q, txrdy_q;

   assign tx_src = thr_full_q ? thr_q : '1;

   i2cs_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl     (flt_lines[1]),
      .sda     (flt_lines[0]),
      .own_addr(own_addr),
      .tx_byte (tx_src),
      .sda_oe  (sda_oe),
      .rw      (rw),
      .ev_match(ev_match),
      .ev_miss (ev_miss),
      .ev_stop (ev_stop),
      .rx_push (rx_push),
      .rx_byte (rx_byte),
      .tx_load (tx_load),
      .tx_done (tx_done)
   );

   wire acc_end = acc_q & (ev_stop | ev_miss);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= 1'b0;
         dir_q      <= 1'b0;
         eoa_q      <= 1'b0;
         rxrdy_q    <= 1'b0;
         txrdy_q    <= 1'b1;
         thr_full_q <= 1'b0;
         thr_q      <= '0;
         rhr_q      <= '0;
      end else begin
         if (ev_match) begin
            acc_q <= 1'b1;
            dir_q <= rw;
         end else if (ev_stop || ev_miss) begin
            acc_q <= 1'b0;
         end
         if (acc_end)      eoa_q <= 1'b1;
         else if (stat_rd) eoa_q <= 1'b0;
         if (rx_push) begin
            rxrdy_q <= 1'b1;
            rhr_q   <= rx_byte;
         end else if (rx_rd) begin
            rxrdy_q <= 1'b0;
         end
         if (tx_load)      txrdy_q <= 1'b0;
         else if (tx_done) txrdy_q <= 1'b1;
         if (tx_wr) begin
            thr_q      <= tx_wdata;
            thr_full_q <= 1'b1;
         end else if (tx_load) begin
            thr_full_q <= 1'b0;
         end
      end
   end

   assign rx_rdata = rhr_q;
   assign st_acc   = acc_q;
   assign st_dir   = dir_q;
   assign st_eoa   = eoa_q;
   assign st_rxrdy = rxrdy_q;
   assign st_txrdy = txrdy_q;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
   input logic clk,
   input logic rst_n,
   input logic acc,
   input logic eoa,
   input logic rxrdy,
   input logic txrdy,
   input logic ev_match,
   input logic ev_miss,
   input logic ev_stop,
   input logic rx_push,
   input logic tx_load,
   input logic tx_done
);
   AST_ACC_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc) |-> $past(ev_match)); // R3
   AST_ACC_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acc) |-> ($past(ev_stop) || $past(ev_miss))); // R6
   AST_EOA_WITH_ACC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoa) |-> $fell(acc)); // R6
   AST_RXRDY_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxrdy) |-> $past(rx_push)); // R5
   AST_TXRDY_DROP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txrdy) |-> $past(tx_load)); // R7
   AST_TXRDY_RISE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txrdy) |-> $past(tx_done)); // R7
endmodule

bind i2c_slave_flags i2cs_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .acc     (acc_q),
   .eoa     (eoa_q),
   .rxrdy   (rxrdy_q),
   .txrdy   (txrdy_q),
   .ev_match(ev_match),
   .ev_miss (ev_miss),
   .ev_stop (ev_stop),
   .rx_push (rx_push),
   .tx_load (tx_load),
   .tx_done (tx_done)
);

// File: tb/tb_i2c_slave_flags.sv
module tb_i2c_slave_flags;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 25;
   localparam logic [6:0] MY_ADDR = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic tx_wr = 1'b0, rx_rd = 1'b0, stat_rd = 1'b0;
   logic [7:0] tx_wdata = 8'h00;
   logic sda_oe, st_acc, st_dir, st_eoa, st_rxrdy, st_txrdy;
   logic [7:0] rx_rdata;
   logic sda_line;
   int errors = 0, checks = 0;
   bit done = 1'b0;
   bit oe_seen = 1'b0;
   bit exp_acc = 0, exp_dir = 0, exp_eoa = 0, exp_rxrdy = 0, exp_txrdy = 1;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_slave_flags dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .own_addr(MY_ADDR), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
      .rx_rdata(rx_rdata), .stat_rd(stat_rd), .st_acc(st_acc), .st_dir(st_dir),
      .st_eoa(st_eoa), .st_rxrdy(st_rxrdy), .st_txrdy(st_txrdy)
   );

   always @(negedge clk) if (sda_oe) oe_seen = 1'b1;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_flags(input string tag);
      check({tag, " acc"}, 8'(st_acc), 8'(exp_acc));
      if (exp_acc) check({tag, " dir"}, 8'(st_dir), 8'(exp_dir));
      check({tag, " eoa"}, 8'(st_eoa), 8'(exp_eoa));
      check({tag, " rxrdy"}, 8'(st_rxrdy), 8'(exp_rxrdy));
      check({tag, " txrdy"}, 8'(st_txrdy), 8'(exp_txrdy));
   endtask

   task automatic phase();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; phase();
      scl_m = 1'b1; phase();
      sda_m = 1'b0; phase();
      scl_m = 1'b0; phase();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; phase();
      scl_m = 1'b1; phase();
      sda_m = 1'b1; phase();
   endtask

   task automatic put_bit(input logic b, input bit glitch);
      sda_m = b; phase();
      if (glitch) begin
         @(negedge clk); scl_m = 1'b1;
         @(negedge clk); scl_m = 1'b0;
         phase();
      end
      scl_m = 1'b1; phase();
      scl_m = 1'b0; phase();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; phase();
      scl_m = 1'b1; phase();
      b = sda_line;
      scl_m = 1'b0; phase();
   endtask

   task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(v[i], glitch && i == 3);
      get_bit(ack);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] v, output logic mid_txrdy);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         get_bit(b);
         v[i] = b;
      end
      sda_m = mack; phase();
      scl_m = 1'b1; phase();
      mid_txrdy = st_txrdy;
      scl_m = 1'b0; phase();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic a;
      logic mid;
      logic [7:0] v;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk_flags("R1 reset");
      check("R1 sda_oe", 8'(sda_oe), 8'h00);

      // Address miss: NACK, nothing stored, no end-of-access
      bus_start();
      send_byte(8'h66, 0, a);
      check("R2 addr nack", 8'(a), 8'h01);
      chk_flags("R2 after miss");
      send_byte(8'h12, 0, a);
      check("R2 data nack", 8'(a), 8'h01);
      chk_flags("R2 data ignored");
      bus_stop();
      chk_flags("R6 stop without access");

      // Master write
      bus_start();
      send_byte({MY_ADDR, 1'b0}, 0, a);
      check("R3 addr ack", 8'(a), 8'h00);
      exp_acc = 1; exp_dir = 0;
      chk_flags("R3 write match");
      send_byte(8'hA5, 1, a);
      check("R5 data ack", 8'(a), 8'h00);
      exp_rxrdy = 1;
      chk_flags("R5 rxrdy set");
      check("R10 glitch ignored data", rx_rdata, 8'hA5);
      pulse(rx_rd);
      exp_rxrdy = 0;
      chk_flags("R5 rxrdy cleared");
      send_byte(8'h3C, 0, a);
      exp_rxrdy = 1;
      check("R5 second byte", rx_rdata, 8'h3C);
      bus_stop();
      exp_acc = 0; exp_eoa = 1;
      chk_flags("R6 stop ends access");
      pulse(stat_rd);
      exp_eoa = 0;
      chk_flags("R6 status read clears eoa");
      pulse(rx_rd);
      exp_rxrdy = 0;

      // Master read
      tx_wdata = 8'h5A;
      pulse(tx_wr);
      bus_start();
      send_byte({MY_ADDR, 1'b1}, 0, a);
      check("R3 read addr ack", 8'(a), 8'h00);
      exp_acc = 1; exp_dir = 1; exp_txrdy = 0;
      chk_flags("R7 load clears txrdy");
      recv_byte(1'b0, v, mid);
      check("R7 read data", v, 8'h5A);
      check("R7 txrdy on master ack", 8'(mid), 8'h01);
      chk_flags("R7 reloaded");
      recv_byte(1'b1, v, mid);
      check("R8 empty gives ones", v, 8'hFF);
      exp_txrdy = 1;
      chk_flags("R9 txrdy after nack");
      oe_seen = 1'b0;
      recv_byte(1'b1, v, mid);
      check("R9 released after nack", 8'(oe_seen), 8'h00);
      bus_stop();
      exp_acc = 0; exp_eoa = 1;
      chk_flags("R6 stop after read");
      pulse(stat_rd);
      exp_eoa = 0;

      // Repeated START handling
      bus_start();
      send_byte({MY_ADDR, 1'b0}, 0, a);
      exp_acc = 1; exp_dir = 0;
      chk_flags("R3 write again");
      bus_start();
      send_byte({MY_ADDR, 1'b1}, 0, a);
      check("R4 re-match ack", 8'(a), 8'h00);
      exp_dir = 1; exp_txrdy = 0;
      chk_flags("R4 repeated start same addr");
      recv_byte(1'b1, v, mid);
      check("R8 empty after sr", v, 8'hFF);
      exp_txrdy = 1;
      bus_start();
      send_byte(8'h66, 0, a);
      check("R2 sr miss nack", 8'(a), 8'h01);
      exp_acc = 0; exp_eoa = 1;
      chk_flags("R6 sr with other addr");
      bus_stop();
      chk_flags("R6 stop keeps eoa");
      pulse(stat_rd);
      exp_eoa = 0;
      chk_flags("R6 final clear");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule